// File: doc/BRIEF.md
# Video Processor Host Port Controller

This block is the host-facing command front end of a tile-based video display processor. The host sends 16-bit words to a control port. Each word is either a register write or the setup of an access address and a 6-bit access code. The block keeps the access address and access code as state. It advances the address after every data-port access. It reports each accepted access to an external memory slot arbiter as a single-cycle strobe, together with the address and code that belong to that access.

Two decoding modes are selected by the `mode5` input. In the newer mode, an address setup takes two words: the first word sets a command-pending flag, and the second word supplies the upper address bits and the upper code bits. In the legacy mode, a single word completes the command. Legacy mode also clears the upper code bits and adds one extra step to each increment.

A narrow host variant joins pairs of control bytes into words. On that bus, the word-wide video memory read code is rewritten into a byte-wide read code. Register storage, write queue timing and memory arbitration live outside this block.

Top module: `hpc_host_port`

## Requirements
- R1: After a synchronous active-high reset, the following outputs are zero: `acc_addr`, `acc_code`, `cmd_pending`, `byte_pending`, `pf_valid` and every strobe.
- R2: When a control word arrives with no command pending and its bits 15:14 equal binary 10, it is a register write. One cycle later, `reg_we` pulses for one cycle with `reg_sel` equal to word bits 12:8 and `reg_val` equal to word bits 7:0.
- R3: When a control word arrives with no command pending, it does three things:
  - It copies word bits 13:0 into address bits 13:0.
  - It leaves address bits 15:14 unchanged.
  - It copies word bits 15:14 into code bits 1:0.
- R4: When such a word arrives, code bits 5:2 are kept if `mode5` is 1 and cleared if `mode5` is 0.
- R5: With `mode5` at 1, a word that is not a register write sets `cmd_pending`. The next control word always completes the command and never writes a register. It sets address bits 15:14 from its bits 1:0, sets code bits 5:2 from its bits 7:4, and clears `cmd_pending`.
- R6: With `mode5` at 0, a word that is not a register write leaves `cmd_pending` at 0 and clears `pf_valid`.
- R7: A word data write (`dat_wr`) or a word data read (`dat_rd`) pulses `dwr_stb` or `drd_stb`, carrying the address and code held before the access. The address then grows by `autoinc`, or by `autoinc`+1 when `mode5` is 0, with 16-bit wraparound. A word data access also clears `cmd_pending`.
- R8: A control read clears both `cmd_pending` and `byte_pending`. `stat_rdata` equals `{open_bus, status_lo}`.
- R9: The first control byte is the low byte. It is held with `byte_pending` set, and the address and code do not change. The second byte is the high byte and completes the word. If the resulting code is 0x00 (the word memory read code), it is replaced with 0x0C (the byte memory read code).
- R10: A byte data write pulses `dwr_stb` with code bit 0 forced to 1 and then advances the address. If a command is pending, the byte data write also clears `cmd_pending`, `byte_pending` and `pf_valid`.
- R11: A byte data read does the following:
  - It clears code bit 0, then maps code 0x00 to 0x0C.
  - It pulses `drd_stb` with that code. When the code is 0x0C, the strobe address has bit 0 inverted.
  - It advances the address and clears `pf_valid` only if `pf_valid` was set.
- R12: A `pf_done` pulse sets `pf_valid`. A word data read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode5 | input | 1 | 1 selects the newer two-word decoding mode |
| autoinc | input | 8 | Auto-increment step from the register file |
| ctl_wr | input | 1 | Word control-port write |
| ctl_wdata | input | 16 | Word written to the control port |
| ctl_rd | input | 1 | Control-port (status) read |
| open_bus | input | 6 | Floating-bus value placed in status bits 15:10 |
| status_lo | input | 10 | Status bits 9:0 from elsewhere in the chip |
| stat_rdata | output | 16 | Status word returned on a control read |
| dat_wr | input | 1 | Word data-port write |
| dat_rd | input | 1 | Word data-port read |
| bctl_wr | input | 1 | Byte control-port write |
| bctl_wdata | input | 8 | Byte written to the control port |
| bdat_wr | input | 1 | Byte data-port write |
| bdat_rd | input | 1 | Byte data-port read |
| pf_done | input | 1 | The arbiter has prefetched read data |
| acc_addr | output | 16 | Current access address |
| acc_code | output | 6 | Current access code |
| cmd_pending | output | 1 | Second command word expected |
| byte_pending | output | 1 | Low control byte held |
| pf_valid | output | 1 | Prefetched read data is present |
| reg_we | output | 1 | Register write pulse |
| reg_sel | output | 5 | Register number |
| reg_val | output | 8 | Register value |
| dwr_stb | output | 1 | Data write pulse to the arbiter |
| drd_stb | output | 1 | Data read pulse to the arbiter |
| xfer_addr | output | 16 | Address of the strobed access |
| xfer_code | output | 6 | Code of the strobed access |

## Verification
The bench sends a second command word whose top bits read as a register write. A design that ignores `cmd_pending` would pulse `reg_we` and leave the address upper bits stale.

It checks that the upper code bits survive a first word in the newer mode but are wiped in legacy mode. It checks the legacy +1 step and an address wrap from 0xFFFE.

On the byte bus, it covers the following cases:
- A low byte that must not disturb the address.
- The rewrite of the word read code to the byte read code.
- The inverted address bit 0 on byte reads.
- A byte read with no prefetch, which must not advance the address.

A design that got any of these wrong would send the arbiter the wrong address or code.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
   // Control word field positions (decoded behaviour)
   localparam int unsigned KIND_HI  = 15;
   localparam int unsigned KIND_LO  = 14;
   localparam logic [1:0]  KIND_REG = 2'b10;
   localparam int unsigned LOW_AW   = 14;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_WR   = 2'd1,
      OP_RD   = 2'd2
   } hpc_op_e;

   function automatic logic [5:0] remap_code(input logic [5:0] c,
                                             input logic [5:0] from_c,
                                             input logic [5:0] to_c);
      return (c == from_c) ? to_c : c;
   endfunction
endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
   import hpc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CODE_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              pend_i,
   input  logic              mode5_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CODE_W-1:0] code_o,
   output logic              pend_o,
   output logic              reg_hit_o,
   output logic              clr_fetch_o
);
   localparam int unsigned UPC_W = CODE_W - 2;
   localparam int unsigned UPA_W = ADDR_W - LOW_AW;

   logic is_reg;
   assign is_reg = (word_i[KIND_HI:KIND_LO] == KIND_REG);

   always_comb begin
      addr_o      = addr_i;
      code_o      = code_i;
      pend_o      = 1'b0;
      reg_hit_o   = 1'b0;
      clr_fetch_o = 1'b0;
      if (pend_i) begin
         // second word of a two-word command
         addr_o[ADDR_W-1:LOW_AW] = word_i[UPA_W-1:0];
         code_o[CODE_W-1:2]      = word_i[4 +: UPC_W];
         clr_fetch_o             = 1'b1;
      end else begin
         addr_o[LOW_AW-1:0] = word_i[LOW_AW-1:0];
         code_o[1:0]        = word_i[KIND_HI:KIND_LO];
         if (!mode5_i)
            code_o[CODE_W-1:2] = '0;
         reg_hit_o   = is_reg;
         pend_o      = !is_reg && mode5_i;
         clr_fetch_o = !is_reg && !mode5_i;
      end
   end
endmodule

// File: rtl/hpc_byte_join.sv
module hpc_byte_join #(
   parameter int unsigned DATA_W  = 16,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_i,
   input  logic [7:0]        byte_i,
   input  logic              clr_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] word_o,
   output logic              pend_o
);
   generate
      if (BYTE_EN) begin : g_join
         logic [7:0] lo_q;
         logic       pend_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               lo_q   <= '0;
               pend_q <= 1'b0;
            end else if (take_i) begin
               if (pend_q) begin
                  pend_q <= 1'b0;
               end else begin
                  lo_q   <= byte_i;
                  pend_q <= 1'b1;
               end
            end else if (clr_i) begin
               pend_q <= 1'b0;
            end
         end
         assign vld_o  = take_i && pend_q;
         assign word_o = {byte_i, lo_q};
         assign pend_o = pend_q;
      end else begin : g_none
         assign vld_o  = 1'b0;
         assign word_o = '0;
         assign pend_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hpc_addr_step.sv
module hpc_addr_step #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned INC_W  = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [INC_W-1:0]  inc_i,
   input  logic              mode5_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] step;
   assign step   = ADDR_W'(inc_i) + ADDR_W'(!mode5_i);
   assign addr_o = addr_i + step;
endmodule

// File: rtl/hpc_host_port.sv
module hpc_host_port
   import hpc_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned CODE_W        = 6,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned INC_W         = 8,
   parameter int unsigned SEL_W         = 5,
   parameter int unsigned VAL_W         = 8,
   parameter int unsigned OPEN_W        = 6,
   parameter bit          BYTE_EN       = 1'b1,
   parameter logic [5:0]  CODE_WORD_VRD = 6'h00,
   parameter logic [5:0]  CODE_BYTE_VRD = 6'h0C
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mode5,
   input  logic [INC_W-1:0]         autoinc,
   input  logic                     ctl_wr,
   input  logic [DATA_W-1:0]        ctl_wdata,
   input  logic                     ctl_rd,
   input  logic [OPEN_W-1:0]        open_bus,
   input  logic [DATA_W-OPEN_W-1:0] status_lo,
   output logic [DATA_W-1:0]        stat_rdata,
   input  logic                     dat_wr,
   input  logic                     dat_rd,
   input  logic                     bctl_wr,
   input  logic [7:0]               bctl_wdata,
   input  logic                     bdat_wr,
   input  logic                     bdat_rd,
   input  logic                     pf_done,
   output logic [ADDR_W-1:0]        acc_addr,
   output logic [CODE_W-1:0]        acc_code,
   output logic                     cmd_pending,
   output logic                     byte_pending,
   output logic                     pf_valid,
   output logic                     reg_we,
   output logic [SEL_W-1:0]         reg_sel,
   output logic [VAL_W-1:0]         reg_val,
   output logic                     dwr_stb,
   output logic                     drd_stb,
   output logic [ADDR_W-1:0]        xfer_addr,
   output logic [CODE_W-1:0]        xfer_code
);
   localparam int unsigned SEL_LSB = VAL_W;

   if (ADDR_W != 16) begin : g_chk_aw
      $error("hpc_host_port: ADDR_W must be 16");
   end
   if (CODE_W != 6) begin : g_chk_cw
      $error("hpc_host_port: CODE_W must be 6");
   end
   if (DATA_W != 16 || SEL_W + VAL_W > LOW_AW) begin : g_chk_dw
      $error("hpc_host_port: bad word field widths");
   end

   // state
   logic [ADDR_W-1:0] addr_q;
   logic [CODE_W-1:0] code_q;
   logic              cpend_q, fetch_q;
   logic              reg_we_q, dwr_q, drd_q;
   logic [SEL_W-1:0]  reg_sel_q;
   logic [VAL_W-1:0]  reg_val_q;
   logic [ADDR_W-1:0] xaddr_q;
   logic [CODE_W-1:0] xcode_q;

   // request priority: control traffic first, then data
   logic busy_ctl, take_cw, take_bw, take_cr, take_dw, take_bdw, take_dr, take_bdr;
   assign busy_ctl = ctl_wr || bctl_wr || ctl_rd;
   assign take_cw  = ctl_wr;
   assign take_bw  = bctl_wr && !ctl_wr && BYTE_EN;
   assign take_cr  = ctl_rd && !ctl_wr && !bctl_wr;
   assign take_dw  = dat_wr && !busy_ctl;
   assign take_bdw = bdat_wr && !busy_ctl && !dat_wr && BYTE_EN;
   assign take_dr  = dat_rd && !busy_ctl && !dat_wr && !bdat_wr;
   assign take_bdr = bdat_rd && !busy_ctl && !dat_wr && !bdat_wr && !dat_rd && BYTE_EN;

   // byte pair assembly
   logic              join_vld, join_pend, join_clr;
   logic [DATA_W-1:0] join_word;
   assign join_clr = take_cr || ((take_bdw || take_bdr) && cpend_q);

   hpc_byte_join #(.DATA_W(DATA_W), .BYTE_EN(BYTE_EN)) u_join (
      .clk(clk), .rst(rst), .take_i(take_bw), .byte_i(bctl_wdata),
      .clr_i(join_clr), .vld_o(join_vld), .word_o(join_word), .pend_o(join_pend)
   );

   // command decode
   logic              cmd_go;
   logic [DATA_W-1:0] cmd_word;
   logic [ADDR_W-1:0] dec_addr;
   logic [CODE_W-1:0] dec_code, dec_code_fix;
   logic              dec_pend, dec_reg, dec_clrf;
   assign cmd_go   = take_cw || join_vld;
   assign cmd_word = take_cw ? ctl_wdata : join_word;

   hpc_cmd_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_dec (
      .word_i(cmd_word), .addr_i(addr_q), .code_i(code_q), .pend_i(cpend_q),
      .mode5_i(mode5), .addr_o(dec_addr), .code_o(dec_code), .pend_o(dec_pend),
      .reg_hit_o(dec_reg), .clr_fetch_o(dec_clrf)
   );

   assign dec_code_fix = take_cw ? dec_code
                                 : remap_code(dec_code, CODE_WORD_VRD, CODE_BYTE_VRD);

   // address advance
   logic [ADDR_W-1:0] addr_next;
   hpc_addr_step #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_step (
      .addr_i(addr_q), .inc_i(autoinc), .mode5_i(mode5), .addr_o(addr_next)
   );

   // byte read code rewrite
   logic [CODE_W-1:0] bread_code;
   assign bread_code = remap_code({code_q[CODE_W-1:1], 1'b0}, CODE_WORD_VRD, CODE_BYTE_VRD);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q    <= '0;
         code_q    <= '0;
         cpend_q   <= 1'b0;
         fetch_q   <= 1'b0;
         reg_we_q  <= 1'b0;
         reg_sel_q <= '0;
         reg_val_q <= '0;
         dwr_q     <= 1'b0;
         drd_q     <= 1'b0;
         xaddr_q   <= '0;
         xcode_q   <= '0;
      end else begin
         reg_we_q <= 1'b0;
         dwr_q    <= 1'b0;
         drd_q    <= 1'b0;
         if (pf_done)
            fetch_q <= 1'b1;
         if (cmd_go) begin
            addr_q  <= dec_addr;
            code_q  <= dec_code_fix;
            cpend_q <= dec_pend;
            if (dec_clrf)
               fetch_q <= 1'b0;
            if (dec_reg) begin
               reg_we_q  <= 1'b1;
               reg_sel_q <= cmd_word[SEL_LSB +: SEL_W];
               reg_val_q <= cmd_word[VAL_W-1:0];
            end
         end else if (take_cr) begin
            cpend_q <= 1'b0;
         end else if (take_dw || take_bdw) begin
            dwr_q   <= 1'b1;
            xaddr_q <= addr_q;
            xcode_q <= take_bdw ? (code_q | CODE_W'(1)) : code_q;
            addr_q  <= addr_next;
            cpend_q <= 1'b0;
            if (take_bdw && cpend_q)
               fetch_q <= 1'b0;
         end else if (take_dr) begin
            drd_q   <= 1'b1;
            xaddr_q <= addr_q;
            xcode_q <= code_q;
            addr_q  <= addr_next;
            cpend_q <= 1'b0;
            fetch_q <= 1'b0;
         end else if (take_bdr) begin
            drd_q   <= 1'b1;
            xcode_q <= bread_code;
            xaddr_q <= (bread_code == CODE_BYTE_VRD) ? (addr_q ^ ADDR_W'(1)) : addr_q;
            code_q  <= bread_code;
            cpend_q <= 1'b0;
            if (fetch_q) begin
               fetch_q <= 1'b0;
               addr_q  <= addr_next;
            end
         end
      end
   end

   assign stat_rdata   = {open_bus, status_lo};
   assign acc_addr     = addr_q;
   assign acc_code     = code_q;
   assign cmd_pending  = cpend_q;
   assign byte_pending = join_pend;
   assign pf_valid     = fetch_q;
   assign reg_we       = reg_we_q;
   assign reg_sel      = reg_sel_q;
   assign reg_val      = reg_val_q;
   assign dwr_stb      = dwr_q;
   assign drd_stb      = drd_q;
   assign xfer_addr    = xaddr_q;
   assign xfer_code    = xcode_q;
endmodule

// File: rtl/hpc_host_port_chk.sv
module hpc_host_port_chk (
   input logic        clk,
   input logic        rst,
   input logic        mode5,
   input logic        ctl_wr,
   input logic [15:0] ctl_wdata,
   input logic        ctl_rd,
   input logic        bctl_wr,
   input logic        dat_wr,
   input logic        dat_rd,
   input logic        bdat_wr,
   input logic        bdat_rd,
   input logic [15:0] acc_addr,
   input logic [5:0]  acc_code,
   input logic        cmd_pending,
   input logic        byte_pending,
   input logic        pf_valid,
   input logic        reg_we,
   input logic        dwr_stb,
   input logic        drd_stb
);
   // R2
   reg_we_src_chk: assert property (@(posedge clk) disable iff (rst)
      reg_we |-> $past(ctl_wr || bctl_wr));

   // R5
   no_reg_on_second_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && cmd_pending) |=> !reg_we && !cmd_pending);

   // R4
   legacy_code_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !cmd_pending && !mode5) |=> (acc_code[5:2] == 4'd0));

   // R6
   legacy_complete_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !cmd_pending && !mode5 && ctl_wdata[15:14] != 2'b10)
      |=> !cmd_pending && !pf_valid);

   // R8
   ctl_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_rd && !ctl_wr && !bctl_wr) |=> !cmd_pending && !byte_pending);

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(ctl_wr || bctl_wr || dat_wr || dat_rd || bdat_wr || bdat_rd) |=> $stable(acc_addr));

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reg_we, dwr_stb, drd_stb}));

   // R10
   dwr_src_chk: assert property (@(posedge clk) disable iff (rst)
      dwr_stb |-> $past(dat_wr || bdat_wr));
endmodule

bind hpc_host_port hpc_host_port_chk u_chk (
   .clk(clk), .rst(rst), .mode5(mode5), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
   .ctl_rd(ctl_rd), .bctl_wr(bctl_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
   .bdat_wr(bdat_wr), .bdat_rd(bdat_rd), .acc_addr(acc_addr), .acc_code(acc_code),
   .cmd_pending(cmd_pending), .byte_pending(byte_pending), .pf_valid(pf_valid),
   .reg_we(reg_we), .dwr_stb(dwr_stb), .drd_stb(drd_stb)
);

// File: tb/hpc_host_port_tb.sv
`timescale 1ns/1ps
module hpc_host_port_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst = 1'b1, mode5 = 1'b0;
   logic [7:0]  autoinc = 8'd0;
   logic        ctl_wr = 0, ctl_rd = 0, dat_wr = 0, dat_rd = 0;
   logic        bctl_wr = 0, bdat_wr = 0, bdat_rd = 0, pf_done = 0;
   logic [15:0] ctl_wdata = '0;
   logic [7:0]  bctl_wdata = '0;
   logic [5:0]  open_bus = 6'h2A;
   logic [9:0]  status_lo = 10'h155;
   logic [15:0] stat_rdata, acc_addr, xfer_addr;
   logic [5:0]  acc_code, xfer_code;
   logic        cmd_pending, byte_pending, pf_valid, reg_we, dwr_stb, drd_stb;
   logic [4:0]  reg_sel;
   logic [7:0]  reg_val;

   hpc_host_port u_dut (
      .clk(clk), .rst(rst), .mode5(mode5), .autoinc(autoinc), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .open_bus(open_bus), .status_lo(status_lo),
      .stat_rdata(stat_rdata), .dat_wr(dat_wr), .dat_rd(dat_rd), .bctl_wr(bctl_wr),
      .bctl_wdata(bctl_wdata), .bdat_wr(bdat_wr), .bdat_rd(bdat_rd), .pf_done(pf_done),
      .acc_addr(acc_addr), .acc_code(acc_code), .cmd_pending(cmd_pending),
      .byte_pending(byte_pending), .pf_valid(pf_valid), .reg_we(reg_we),
      .reg_sel(reg_sel), .reg_val(reg_val), .dwr_stb(dwr_stb), .drd_stb(drd_stb),
      .xfer_addr(xfer_addr), .xfer_code(xfer_code)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;   // 0 register, 1 write, 2 read
      logic [15:0] a;      // address or {sel,val}
      logic [5:0]  c;
      string       tag;
   } item_t;
   item_t exp_q[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input int k, input logic [15:0] a, input logic [5:0] c, input string tag);
      item_t it;
      it.kind = k; it.a = a; it.c = c; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: pop an expected item for every strobe
   always @(negedge clk) begin
      if (!rst && (reg_we || dwr_stb || drd_stb)) begin
         int k;
         logic [15:0] a;
         logic [5:0]  c;
         item_t it;
         k = reg_we ? 0 : (dwr_stb ? 1 : 2);
         a = reg_we ? {3'd0, reg_sel, reg_val} : xfer_addr;
         c = reg_we ? 6'd0 : xfer_code;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL unexpected strobe (R2/R5/R7) actual kind=%0d addr=%0h expected none", k, a);
         end else begin
            it = exp_q.pop_front();
            chk({it.tag, " kind"}, k, it.kind);
            chk({it.tag, " addr"}, a, it.a);
            chk({it.tag, " code"}, c, it.c);
         end
      end
   end

   task automatic pulse_ctl(input logic [15:0] w);
      @(negedge clk); ctl_wr = 1; ctl_wdata = w;
      @(negedge clk); ctl_wr = 0;
   endtask
   task automatic pulse_bctl(input logic [7:0] b);
      @(negedge clk); bctl_wr = 1; bctl_wdata = b;
      @(negedge clk); bctl_wr = 0;
   endtask
   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ctl_rd = 1; 1: dat_wr = 1; 2: dat_rd = 1;
         3: bdat_wr = 1; 4: bdat_rd = 1; default: pf_done = 1;
      endcase
      @(negedge clk);
      ctl_rd = 0; dat_wr = 0; dat_rd = 0; bdat_wr = 0; bdat_rd = 0; pf_done = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk("R1 addr", acc_addr, 0); chk("R1 code", acc_code, 0);
      chk("R1 pend", {cmd_pending, byte_pending, pf_valid}, 0);
      chk("R1 strobes", {reg_we, dwr_stb, drd_stb}, 0);

      mode5 = 1; autoinc = 8'd2;
      push(0, 16'h0F12, 6'd0, "R2");
      pulse_ctl(16'h8F12);
      chk("R3 addr", acc_addr, 16'h0F12); chk("R3 code", acc_code, 6'h02);

      pulse_ctl(16'h4123);
      chk("R5 pend set", cmd_pending, 1); chk("R3 addr", acc_addr, 16'h0123);
      pulse_ctl(16'h80B2);   // second word looks like a register write
      chk("R5 pend clr", cmd_pending, 0);
      chk("R5 addr", acc_addr, 16'h8123); chk("R5 code", acc_code, 6'h2D);

      pulse_ctl(16'h0456);
      chk("R4 code kept", acc_code, 6'h2C); chk("R3 addr keep hi", acc_addr, 16'h8456);
      pulse(0);
      chk("R8 pend clr", cmd_pending, 0);
      chk("R8 status", stat_rdata, 16'hA955);

      push(1, 16'h8456, 6'h2C, "R7 wr");
      pulse(1);
      chk("R7 addr", acc_addr, 16'h8458);
      push(2, 16'h8458, 6'h2C, "R7 rd");
      pulse(2);
      chk("R7 addr", acc_addr, 16'h845A);

      // legacy mode
      mode5 = 0;
      pulse(5);
      chk("R12 pf set", pf_valid, 1);
      pulse_ctl(16'h4ABC);
      chk("R4 code clr", acc_code, 6'h01); chk("R6 addr", acc_addr, 16'h8ABC);
      chk("R6 no pend", cmd_pending, 0); chk("R6 pf clr", pf_valid, 0);
      push(1, 16'h8ABC, 6'h01, "R7 legacy");
      pulse(1);
      chk("R7 legacy +1", acc_addr, 16'h8ABF);

      // byte bus
      pulse_bctl(8'h00);
      chk("R9 byte pend", byte_pending, 1); chk("R9 addr hold", acc_addr, 16'h8ABF);
      chk("R9 code hold", acc_code, 6'h01);
      pulse_bctl(8'h01);
      chk("R9 addr", acc_addr, 16'h8100); chk("R9 rewrite", acc_code, 6'h0C);
      chk("R9 pend clr", byte_pending, 0);

      push(2, 16'h8101, 6'h0C, "R11 no pf");
      pulse(4);
      chk("R11 no advance", acc_addr, 16'h8100);
      pulse(5);
      push(2, 16'h8101, 6'h0C, "R11 pf");
      pulse(4);
      chk("R11 advance", acc_addr, 16'h8103); chk("R11 pf clr", pf_valid, 0);
      push(1, 16'h8103, 6'h0D, "R10 wr");
      pulse(3);
      chk("R10 addr", acc_addr, 16'h8106);

      mode5 = 1;
      pulse_bctl(8'h34); pulse_bctl(8'h52);
      chk("R9 word", acc_addr, 16'h9234); chk("R5 pend", cmd_pending, 1);
      chk("R4 byte code", acc_code, 6'h0D);
      pulse_bctl(8'h77);
      push(1, 16'h9234, 6'h0D, "R10 pending");
      pulse(3);
      chk("R10 clr", {cmd_pending, byte_pending}, 0);
      chk("R10 addr", acc_addr, 16'h9236);

      mode5 = 0;
      pulse_ctl(16'h4000);
      push(2, 16'h8001, 6'h0C, "R11 rewrite");
      pulse(4);
      chk("R11 code", acc_code, 6'h0C); chk("R11 addr", acc_addr, 16'h8000);

      pulse_bctl(8'h11);
      pulse(0);
      chk("R8 byte clr", byte_pending, 0);

      // wrap
      mode5 = 1; autoinc = 8'd4;
      pulse_ctl(16'h3FFE); pulse_ctl(16'h0003);
      chk("R5 addr hi", acc_addr, 16'hFFFE); chk("R5 code", acc_code, 6'h00);
      push(1, 16'hFFFE, 6'h00, "R7 wrap");
      pulse(1);
      chk("R7 wrap", acc_addr, 16'h0002);
      pulse(5);
      push(2, 16'h0002, 6'h00, "R12 rd");
      pulse(2);
      chk("R12 pf clr", pf_valid, 0); chk("R7 addr", acc_addr, 16'h0006);

      repeat (3) @(negedge clk);
      chk("R7 queue drained", exp_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule